// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor with five stages: fetch, decode, execute, memory access and write-back. It runs a reduced integer instruction set. That set covers register-register add, subtract, AND, OR and signed set-less-than. It also covers the immediate forms of add, AND, OR and set-less-than, plus word load, word store and branch-if-equal. One instruction enters per clock and up to five are in flight at once. The core holds its own instruction memory, data memory and a 32-entry register file.

Control is decoded once in the decode stage. It travels down the pipeline as three bundles, one each for execute, memory and write-back, and each bundle is dropped after the stage that uses it. The ALU operation is chosen in two levels. The main decoder emits a two-bit class code. For register-register instructions the function field picks the operation, and for immediate instructions the opcode picks it. The core has no hazard detection, no forwarding and no flush, so programs must place independent instructions or nops between dependent ones.

The instruction memory is loaded through a write port while the core is held in reset. Results can be seen on a write-back bus and on a data-store bus.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the fetch address is 0. No register write and no data store is reported until the first instruction reaches write-back or memory.
- R2: Without a taken branch, the fetch address rises by 4 every clock. The instruction at word k after reset has its register write reported in cycle k+4.
- R3: Opcode 000000 selects a register-register operation by its low six bits. 100000 is add, 100010 is subtract, 100100 is AND, 100101 is OR and 101010 is signed set-less-than. The destination is bits 15:11.
- R4: The immediate opcodes are 001000 add, 001100 AND, 001101 OR and 001010 signed set-less-than. Each writes the register in bits 20:16. The 16-bit immediate is sign-extended for all four, including AND and OR.
- R5: Opcode 101011 stores the register in bits 20:16 to byte address rs+sign-extended offset. Opcode 100011 loads that word into the register in bits 20:16. A load issued after a store returns the stored word.
- R6: Opcode 000100 compares two registers in execute. When they are equal, fetch continues at PC+4+(sign-extended offset<<2) from the cycle after the branch is in the memory stage. The three instructions already fetched behind it still complete. When they are not equal, nothing changes.
- R7: Register 0 always reads as zero. Writes to it are dropped and are not reported on the write-back bus.
- R8: A register read in decode during the same cycle that write-back writes that register returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction memory write enable |
| prog_addr | input | 6 | Instruction memory word index |
| prog_data | input | 32 | Instruction word to store |
| pc | output | 32 | Current fetch byte address |
| wb_we | output | 1 | A register is written this cycle |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 32 | Value being written |
| dmem_we | output | 1 | A data word is stored this cycle |
| dmem_addr | output | 32 | Byte address of the store |
| dmem_wdata | output | 32 | Word being stored |

## Verification
The bench builds the core with its default depth of 64 words for both memories. That depth holds a 32-instruction program, with room for the branch target beyond the taken branch, and gives data addresses 8 and 16 without wrap. The program uses exactly two nops between a producer and its consumer, so the same-cycle write-then-read path is on the critical dependency. Its branches can be told apart by a skipped write and a kept write in the write-back log. A reset asserted mid-run then shows the pipeline restart from address 0.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_SLTI  = 6'b001010;

  typedef enum logic [2:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110,
    FN_SLT = 3'b111
  } alu_fn_e;

  // execute-stage controls
  typedef struct packed {
    logic       dst_rd;
    logic [1:0] cls;
    logic       use_imm;
  } ex_ctl_t;

  // memory-stage controls
  typedef struct packed {
    logic branch;
    logic rd_en;
    logic wr_en;
  } mem_ctl_t;

  // write-back controls
  typedef struct packed {
    logic reg_we;
    logic from_mem;
  } wb_ctl_t;

  typedef struct packed {
    logic [31:0] pc4;
    logic [31:0] instr;
  } ifid_t;

  typedef struct packed {
    ex_ctl_t     ex;
    mem_ctl_t    mem;
    wb_ctl_t     wb;
    logic [31:0] pc4;
    logic [31:0] a_val;
    logic [31:0] b_val;
    logic [31:0] imm;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [5:0]  funct;
    logic [5:0]  opcode;
  } idex_t;

  typedef struct packed {
    mem_ctl_t    mem;
    wb_ctl_t     wb;
    logic [31:0] target;
    logic        zero;
    logic [31:0] alu_y;
    logic [31:0] store;
    logic [4:0]  dst;
  } exmem_t;

  typedef struct packed {
    wb_ctl_t     wb;
    logic [31:0] load;
    logic [31:0] alu_y;
    logic [4:0]  dst;
  } memwb_t;

endpackage

// File: rtl/p5_main_dec.sv
module p5_main_dec
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  output ex_ctl_t    ex,
  output mem_ctl_t   mem,
  output wb_ctl_t    wb
);
  always_comb begin
    ex  = '0;
    mem = '0;
    wb  = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ex.dst_rd = 1'b1; ex.cls = 2'b10; wb.reg_we = 1'b1;
      end
      OP_LW: begin
        ex.use_imm = 1'b1; mem.rd_en = 1'b1; wb.reg_we = 1'b1; wb.from_mem = 1'b1;
      end
      OP_SW: begin
        ex.use_imm = 1'b1; mem.wr_en = 1'b1;
      end
      OP_BEQ: begin
        ex.cls = 2'b01; mem.branch = 1'b1;
      end
      OP_ADDI, OP_ANDI, OP_ORI, OP_SLTI: begin
        ex.cls = 2'b11; ex.use_imm = 1'b1; wb.reg_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/p5_exec.sv
module p5_exec
  import pipe5_pkg::*;
(
  input  logic [1:0]  cls,
  input  logic [5:0]  funct,
  input  logic [5:0]  opcode,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] y,
  output logic        zero
);
  alu_fn_e fn;

  // second-level decode: class code, then funct or opcode
  always_comb begin
    fn = FN_ADD;
    unique case (cls)
      2'b00: fn = FN_ADD;
      2'b01: fn = FN_SUB;
      2'b10:
        case (funct)
          6'b100010: fn = FN_SUB;
          6'b100100: fn = FN_AND;
          6'b100101: fn = FN_OR;
          6'b101010: fn = FN_SLT;
          default:   fn = FN_ADD;
        endcase
      2'b11:
        case (opcode)
          OP_ANDI: fn = FN_AND;
          OP_ORI:  fn = FN_OR;
          OP_SLTI: fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      default: fn = FN_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_SUB:  y = a - b;
      FN_SLT:  y = {31'd0, $signed(a) < $signed(b)};
      default: y = a + b;
    endcase
  end

  assign zero = (y == 32'd0);
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int NREGS = 32,
  localparam int RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic [RW-1:0] ra1,
  input  logic [RW-1:0] ra2,
  output logic [31:0]   rd1,
  output logic [31:0]   rd2,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [31:0]   wd
);
  logic [31:0] regs [NREGS];
  logic        wr_live;

  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[wa] <= wd;
  end

  // register 0 pinned to zero; same-cycle write passes straight through
  always_comb begin
    if (ra1 == '0)                   rd1 = '0;
    else if (wr_live && wa == ra1)   rd1 = wd;
    else                             rd1 = regs[ra1];
    if (ra2 == '0)                   rd2 = '0;
    else if (wr_live && wa == ra2)   rd2 = wd;
    else                             rd2 = regs[ra2];
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_we,
  input  logic [IAW-1:0] prog_addr,
  input  logic [31:0]    prog_data,
  output logic [31:0]    pc,
  output logic           wb_we,
  output logic [4:0]     wb_reg,
  output logic [31:0]    wb_data,
  output logic           dmem_we,
  output logic [31:0]    dmem_addr,
  output logic [31:0]    dmem_wdata
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc_q, pc_d;
  ifid_t  ifid_q, ifid_d;
  idex_t  idex_q, idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  ex_ctl_t  dec_ex;
  mem_ctl_t dec_mem;
  wb_ctl_t  dec_wb;
  logic [31:0] rs_val, rt_val, ex_b, ex_y, ld_word;
  logic        ex_zero, take_br;
  logic [31:0] br_tgt;
  mem_ctl_t    mem_flags;
  logic        unused_shamt;

  // instruction memory load port
  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  // ---------------- IF
  assign take_br = exmem_q.mem.branch && exmem_q.zero;
  assign br_tgt  = exmem_q.target;
  assign pc_d    = take_br ? br_tgt : pc_q + 32'd4;
  assign ifid_d  = '{pc4: pc_q + 32'd4, instr: imem[pc_q[IAW+1:2]]};

  // ---------------- ID
  assign unused_shamt = ^ifid_q.instr[10:6];

  p5_main_dec u_dec (
    .opcode (ifid_q.instr[31:26]),
    .ex     (dec_ex),
    .mem    (dec_mem),
    .wb     (dec_wb)
  );

  p5_regfile #(.NREGS(32)) u_rf (
    .clk (clk),
    .ra1 (ifid_q.instr[25:21]),
    .ra2 (ifid_q.instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (memwb_q.wb.reg_we),
    .wa  (memwb_q.dst),
    .wd  (wb_data)
  );

  always_comb begin
    idex_d.ex     = dec_ex;
    idex_d.mem    = dec_mem;
    idex_d.wb     = dec_wb;
    idex_d.pc4    = ifid_q.pc4;
    idex_d.a_val  = rs_val;
    idex_d.b_val  = rt_val;
    idex_d.imm    = {{16{ifid_q.instr[15]}}, ifid_q.instr[15:0]};
    idex_d.rt     = ifid_q.instr[20:16];
    idex_d.rd     = ifid_q.instr[15:11];
    idex_d.funct  = ifid_q.instr[5:0];
    idex_d.opcode = ifid_q.instr[31:26];
  end

  // ---------------- EX
  assign ex_b = idex_q.ex.use_imm ? idex_q.imm : idex_q.b_val;

  p5_exec u_exec (
    .cls    (idex_q.ex.cls),
    .funct  (idex_q.funct),
    .opcode (idex_q.opcode),
    .a      (idex_q.a_val),
    .b      (ex_b),
    .y      (ex_y),
    .zero   (ex_zero)
  );

  always_comb begin
    exmem_d.mem    = idex_q.mem;
    exmem_d.wb     = idex_q.wb;
    exmem_d.target = idex_q.pc4 + {idex_q.imm[29:0], 2'b00};
    exmem_d.zero   = ex_zero;
    exmem_d.alu_y  = ex_y;
    exmem_d.store  = idex_q.b_val;
    exmem_d.dst    = idex_q.ex.dst_rd ? idex_q.rd : idex_q.rt;
  end

  // ---------------- MEM
  assign mem_flags = exmem_q.mem;
  assign ld_word   = dmem[exmem_q.alu_y[DAW+1:2]];

  always_ff @(posedge clk) begin
    if (exmem_q.mem.wr_en) dmem[exmem_q.alu_y[DAW+1:2]] <= exmem_q.store;
  end

  assign memwb_d = '{wb: exmem_q.wb, load: ld_word, alu_y: exmem_q.alu_y, dst: exmem_q.dst};

  // ---------------- pipeline registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  // ---------------- WB and observation
  assign pc         = pc_q;
  assign wb_data    = memwb_q.wb.from_mem ? memwb_q.load : memwb_q.alu_y;
  assign wb_reg     = memwb_q.dst;
  assign wb_we      = memwb_q.wb.reg_we && (memwb_q.dst != 5'd0);
  assign dmem_we    = exmem_q.mem.wr_en;
  assign dmem_addr  = exmem_q.alu_y;
  assign dmem_wdata = exmem_q.store;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
  import pipe5_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic        take_br,
  input logic [31:0] br_tgt,
  input mem_ctl_t    mem_flags,
  input logic        wb_we,
  input logic [4:0]  wb_reg,
  input logic        dmem_we
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assert_pc_zero_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == 32'd0);

  assert_no_early_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst < 3'd4 |-> !wb_we);

  assert_no_early_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst < 3'd3 |-> !dmem_we);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_br |=> pc == $past(pc) + 32'd4);

  assert_branch_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_br |=> pc == $past(br_tgt));

  assert_mem_ctl_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_flags.branch, mem_flags.rd_en, mem_flags.wr_en}));

  assert_no_zero_reg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> wb_reg != 5'd0);
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc        (pc),
  .take_br   (take_br),
  .br_tgt    (br_tgt),
  .mem_flags (mem_flags),
  .wb_we     (wb_we),
  .wb_reg    (wb_reg),
  .dmem_we   (dmem_we)
);

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc, wb_data, dmem_addr, dmem_wdata;
  logic        wb_we, dmem_we;
  logic [4:0]  wb_reg;

  always #10 clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc(pc), .wb_we(wb_we), .wb_reg(wb_reg),
    .wb_data(wb_data), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata)
  );

  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] rr(input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  localparam logic [31:0] PROG [32] = '{
    ri(6'h08, 0, 1, 16'd5),        // 0  addi
    ri(6'h08, 0, 2, 16'hFFFD),     // 1  addi negative
    ri(6'h0D, 0, 3, 16'h00F0),     // 2  ori
    32'd0, 32'd0,
    rr(1, 2, 4, 6'h20),            // 5  add
    rr(1, 2, 5, 6'h22),            // 6  sub
    rr(2, 3, 6, 6'h24),            // 7  and
    rr(1, 3, 7, 6'h25),            // 8  or
    rr(2, 1, 8, 6'h2A),            // 9  slt
    ri(6'h0A, 1, 9, 16'hFFFF),     // 10 slti
    ri(6'h0C, 2, 10, 16'hFF00),    // 11 andi, sign-extended
    ri(6'h2B, 0, 7, 16'd8),        // 12 sw
    ri(6'h23, 0, 11, 16'd8),       // 13 lw
    ri(6'h04, 1, 1, 16'd4),        // 14 beq taken -> word 19
    32'd0, 32'd0, 32'd0,
    ri(6'h08, 0, 15, 16'd99),      // 18 skipped
    ri(6'h08, 0, 12, 16'd7),       // 19
    ri(6'h04, 1, 2, 16'd5),        // 20 beq not taken
    32'd0, 32'd0, 32'd0,
    ri(6'h08, 0, 13, 16'd9),       // 24
    rr(1, 1, 0, 6'h20),            // 25 write to register 0
    32'd0, 32'd0,
    rr(0, 1, 14, 6'h20),           // 28
    32'd0, 32'd0,
    ri(6'h2B, 0, 14, 16'd16)       // 31 sw, two-nop gap
  };

  // {requirement tag, register, value}
  localparam logic [40:0] EXP_WB [14] = '{
    {4'd4, 5'd1,  32'd5},
    {4'd4, 5'd2,  32'hFFFF_FFFD},
    {4'd4, 5'd3,  32'h0000_00F0},
    {4'd3, 5'd4,  32'd2},
    {4'd3, 5'd5,  32'd8},
    {4'd3, 5'd6,  32'h0000_00F0},
    {4'd3, 5'd7,  32'h0000_00F5},
    {4'd3, 5'd8,  32'd1},
    {4'd4, 5'd9,  32'd0},
    {4'd4, 5'd10, 32'hFFFF_FF00},
    {4'd5, 5'd11, 32'h0000_00F5},
    {4'd6, 5'd12, 32'd7},
    {4'd6, 5'd13, 32'd9},
    {4'd7, 5'd14, 32'd5}
  };

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic logging = 1'b0;
  logic done = 1'b0;
  logic [36:0] wb_log [32];
  int          wb_cyc [32];
  int wb_n = 0;
  logic [63:0] st_log [4];
  int st_n = 0;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    else       cyc <= 0;
  end

  always @(negedge clk) begin
    if (rst_n && logging) begin
      if (wb_we && wb_n < 32) begin
        wb_log[wb_n] = {wb_reg, wb_data};
        wb_cyc[wb_n] = cyc;
        wb_n++;
      end
      if (dmem_we && st_n < 4) begin
        st_log[st_n] = {dmem_addr, dmem_wdata};
        st_n++;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic to_cycle(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // load program and zero-fill while held in reset
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = 6'(i);
      prog_data = (i < 32) ? PROG[i] : 32'd0;
    end
    @(negedge clk);
    prog_we = 1'b0;
    // R1: reset state
    check("R1", "pc in reset", 64'(pc), 64'd0);
    check("R1", "wb_we in reset", 64'(wb_we), 64'd0);
    check("R1", "dmem_we in reset", 64'(dmem_we), 64'd0);
    rst_n   = 1'b1;
    logging = 1'b1;
    #1;
    check("R1", "pc cycle 0", 64'(pc), 64'd0);
    to_cycle(3);
    check("R2", "pc cycle 3", 64'(pc), 64'd12);
    check("R1", "no write before cycle 4", 64'(wb_n), 64'd0);
    to_cycle(18);
    check("R6", "pc after taken branch", 64'(pc), 64'd76);
    to_cycle(45);
    logging = 1'b0;

    check("R2", "first write cycle", 64'(wb_cyc[0]), 64'd4);
    check("R7", "write count (reg 0 and skipped word absent)", 64'(wb_n), 64'd14);
    for (int i = 0; i < 14; i++) begin
      if (i < wb_n)
        check(tag_name(EXP_WB[i][40:37]), $sformatf("write %0d", i),
              64'(wb_log[i]), 64'(EXP_WB[i][36:0]));
    end
    check("R5", "store count", 64'(st_n), 64'd2);
    check("R5", "first store", st_log[0], {32'd8, 32'h0000_00F5});
    check("R8", "second store uses same-cycle written value", st_log[1], {32'd16, 32'd5});

    // R1: reset in mid-run, then restart
    rst_n = 1'b0;
    #1;
    check("R1", "pc on mid-run reset", 64'(pc), 64'd0);
    check("R1", "wb_we on mid-run reset", 64'(wb_we), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    to_cycle(2);
    check("R2", "pc after restart", 64'(pc), 64'd8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule